// File: doc/BRIEF.md
# Split-Register Motion Delta Accumulator

This block collects the signed X and Y displacement that a motion engine reports once per frame. It sums the steps into two 12-bit two's-complement counters and shows each counter to a register port as bytes. Each axis has a low byte, and one shared high byte packs the upper nibble of both axes. A status byte carries a motion-pending flag and an overflow flag. An active-low motion pin mirrors the pending flag, so a host controller can wait on the pin instead of polling.

The register port gives the block four strobes: a status read, a status write, a high-byte read and a threshold write. A status read freezes the values on the byte outputs for readout. Frames that arrive while that readout is open go into a second accumulator. When the high byte is read, the second accumulator becomes the visible one. A status write wipes everything. A lift detector compares the frame's 16-bit shutter value against a programmable threshold and drops frames taken with the device lifted off the surface.

Top module: `motion_delta_accum`

## Requirements
- R1: Each accepted frame adds its signed dx and dy (FRAME_W bits each) to 12-bit two's-complement sums. `deltaXLo` shows X[7:0] and `deltaYLo` shows Y[7:0], one cycle after the frame.
- R2: `deltaHi` carries X[11:8] in bits 7:4 and Y[11:8] in bits 3:0.
- R3: Status bit 7 (MOT) is set by an accepted frame with a nonzero dx or dy. A frame with dx and dy both zero does not set it. `motionN` is low exactly while MOT is set.
- R4: A frame that would take either axis outside -2048..2047 is dropped and sets status bit 4 (OVF). Both sums keep their last in-range values. Later frames are ignored until a high-byte read or a status write. All other status bits read 0.
- R5: A status write clears MOT, OVF, both sums and any frames buffered during a readout. A frame in the same cycle is discarded.
- R6: A high-byte read replaces the visible sums, MOT and OVF with the contents of the second accumulator. Without an open readout, that content is zero.
- R7: A status read opens a readout. From that cycle until the high-byte read, the byte outputs hold still and accepted frames go into the second accumulator.
- R8: A frame accepted in the same cycle as a high-byte read is added on top of the values that read brings in.
- R9: A frame is dropped, and MOT is left unchanged, when the shutter value is greater than `thrValue[7:1]` × 32. A shutter equal to that bound is accepted.
- R10: The threshold register resets to 0x56. A threshold write loads `thrWrData`, and `thrValue` shows the stored value.
- R11: After reset, the status byte and all delta bytes are zero and `motionN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | A frame result is present this cycle |
| frameDx | input | FRAME_W | Signed X step of the frame |
| frameDy | input | FRAME_W | Signed Y step of the frame |
| shutter | input | SHUT_W | Shutter value of the frame |
| statusRd | input | 1 | Status byte is being read; opens a readout |
| statusWr | input | 1 | Status byte is being written; clears all motion state |
| highRd | input | 1 | Packed high byte is being read; closes the readout |
| thrWr | input | 1 | Load the lift threshold |
| thrWrData | input | 8 | New lift threshold |
| statusByte | output | 8 | MOT in bit 7, OVF in bit 4 |
| deltaXLo | output | 8 | X[7:0] |
| deltaYLo | output | 8 | Y[7:0] |
| deltaHi | output | 8 | {X[11:8], Y[11:8]} |
| motionN | output | 1 | Low while motion is pending |
| thrValue | output | 8 | Stored lift threshold |

## Verification
The bench builds the block with its defaults, FRAME_W = 8 and SHUT_W = 16. With these values every possible single-frame dx is swept against a paired dy, and a run of sixteen full-scale frames reaches exactly -2048 and +2032. That puts both overflow edges within a few frames. The 16-bit shutter covers every bound that the 8-bit threshold can produce, so all 256 threshold values are tried with the shutter set exactly at the bound and one above it.

// File: rtl/mda_pkg.sv
package mda_pkg;
  localparam int DELTA_W = 12;
  localparam int BYTE_W = 8;
  localparam int NIB_W = DELTA_W - BYTE_W;
  localparam int LIM_SHIFT = 5;
  localparam int LIM_W = 7 + LIM_SHIFT;
  localparam int MOT_BIT = 7;
  localparam int OVF_BIT = 4;

  typedef struct packed {
    logic clearAll;
    logic mergeFresh;
    logic addMain;
    logic addFresh;
  } mdaStrobes_t;
endpackage

// File: rtl/mda_acc.sv
module mda_acc
  import mda_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clr,
  input  logic               loadEn,
  input  logic [DELTA_W-1:0] loadX,
  input  logic [DELTA_W-1:0] loadY,
  input  logic               loadOvf,
  input  logic               loadMot,
  input  logic               add,
  input  logic [FRAME_W-1:0] dx,
  input  logic [FRAME_W-1:0] dy,
  output logic [DELTA_W-1:0] accX,
  output logic [DELTA_W-1:0] accY,
  output logic               ovf,
  output logic               mot
);
  localparam int EXT_W = DELTA_W + 1 - FRAME_W;

  logic [1:0][DELTA_W-1:0] cur;
  logic [1:0][DELTA_W-1:0] baseV;
  logic [1:0][DELTA_W-1:0] nxtV;
  logic [1:0][DELTA_W-1:0] ldV;
  logic [1:0][FRAME_W-1:0] step;
  logic [1:0]              axOvf;
  logic                    baseOvf;
  logic                    baseMot;
  logic                    nonZero;

  assign ldV  = {loadY, loadX};
  assign step = {dy, dx};

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic [DELTA_W:0] sum;
    assign baseV[a] = loadEn ? ldV[a] : cur[a];
    assign sum = {baseV[a][DELTA_W-1], baseV[a]}
               + {{EXT_W{step[a][FRAME_W-1]}}, step[a]};
    assign axOvf[a] = sum[DELTA_W] ^ sum[DELTA_W-1];
    assign nxtV[a] = sum[DELTA_W-1:0];
  end

  assign baseOvf = loadEn ? loadOvf : ovf;
  assign baseMot = loadEn ? loadMot : mot;
  assign nonZero = (|dx) | (|dy);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur <= '0;
      ovf <= 1'b0;
      mot <= 1'b0;
    end else if (clr) begin
      cur <= '0;
      ovf <= 1'b0;
      mot <= 1'b0;
    end else begin
      if (add && !baseOvf) begin
        if (|axOvf) begin
          cur <= baseV;
          ovf <= 1'b1;
        end else begin
          cur <= nxtV;
          ovf <= 1'b0;
        end
      end else begin
        cur <= baseV;
        ovf <= baseOvf;
      end
      mot <= baseMot | (add & nonZero);
    end
  end

  assign accX = cur[0];
  assign accY = cur[1];
endmodule

// File: rtl/mda_ctrl.sv
module mda_ctrl
  import mda_pkg::*;
#(
  parameter int         SHUT_W    = 16,
  parameter logic [7:0] THR_RESET = 8'h56
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [SHUT_W-1:0] shutter,
  input  logic              statusRd,
  input  logic              statusWr,
  input  logic              highRd,
  input  logic              thrWr,
  input  logic [7:0]        thrWrData,
  output mdaStrobes_t       stb,
  output logic [7:0]        thrValue
);
  localparam int CMP_W = SHUT_W + LIM_W;

  logic [7:0]       thrReg;
  logic             pending;
  logic [CMP_W-1:0] shutWide;
  logic [CMP_W-1:0] limWide;
  logic             lifted;
  logic             frameGo;
  logic             toFresh;

  assign shutWide = {{LIM_W{1'b0}}, shutter};
  assign limWide  = {{SHUT_W{1'b0}}, thrReg[7:1], {LIM_SHIFT{1'b0}}};
  assign lifted   = shutWide > limWide;

  assign frameGo = frameValid & ~lifted & ~statusWr;
  assign toFresh = (pending | statusRd) & ~highRd;

  always_comb begin
    stb            = '0;
    stb.clearAll   = statusWr;
    stb.mergeFresh = highRd & ~statusWr;
    stb.addMain    = frameGo & ~toFresh;
    stb.addFresh   = frameGo & toFresh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (statusWr || highRd) begin
      pending <= 1'b0;
    end else if (statusRd) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrReg <= THR_RESET;
    end else if (thrWr) begin
      thrReg <= thrWrData;
    end
  end

  assign thrValue = thrReg;
endmodule

// File: rtl/mda_datapath.sv
module mda_datapath
  import mda_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  mdaStrobes_t        stb,
  input  logic [FRAME_W-1:0] frameDx,
  input  logic [FRAME_W-1:0] frameDy,
  output logic [7:0]         statusByte,
  output logic [7:0]         deltaXLo,
  output logic [7:0]         deltaYLo,
  output logic [7:0]         deltaHi,
  output logic               motionN
);
  logic [DELTA_W-1:0] mainX;
  logic [DELTA_W-1:0] mainY;
  logic [DELTA_W-1:0] freshX;
  logic [DELTA_W-1:0] freshY;
  logic               mainOvf;
  logic               mainMot;
  logic               freshOvf;
  logic               freshMot;

  mda_acc #(.FRAME_W(FRAME_W)) u_main (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (stb.clearAll),
    .loadEn  (stb.mergeFresh),
    .loadX   (freshX),
    .loadY   (freshY),
    .loadOvf (freshOvf),
    .loadMot (freshMot),
    .add     (stb.addMain),
    .dx      (frameDx),
    .dy      (frameDy),
    .accX    (mainX),
    .accY    (mainY),
    .ovf     (mainOvf),
    .mot     (mainMot)
  );

  mda_acc #(.FRAME_W(FRAME_W)) u_fresh (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (stb.clearAll | stb.mergeFresh),
    .loadEn  (1'b0),
    .loadX   ('0),
    .loadY   ('0),
    .loadOvf (1'b0),
    .loadMot (1'b0),
    .add     (stb.addFresh),
    .dx      (frameDx),
    .dy      (frameDy),
    .accX    (freshX),
    .accY    (freshY),
    .ovf     (freshOvf),
    .mot     (freshMot)
  );

  always_comb begin
    statusByte          = '0;
    statusByte[MOT_BIT] = mainMot;
    statusByte[OVF_BIT] = mainOvf;
  end

  assign deltaXLo = mainX[BYTE_W-1:0];
  assign deltaYLo = mainY[BYTE_W-1:0];
  assign deltaHi  = {mainX[DELTA_W-1:BYTE_W], mainY[DELTA_W-1:BYTE_W]};
  assign motionN  = ~mainMot;
endmodule

// File: rtl/motion_delta_accum.sv
module motion_delta_accum
  import mda_pkg::*;
#(
  parameter int         FRAME_W   = 8,
  parameter int         SHUT_W    = 16,
  parameter logic [7:0] THR_RESET = 8'h56
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameDx,
  input  logic [FRAME_W-1:0] frameDy,
  input  logic [SHUT_W-1:0]  shutter,
  input  logic               statusRd,
  input  logic               statusWr,
  input  logic               highRd,
  input  logic               thrWr,
  input  logic [7:0]         thrWrData,
  output logic [7:0]         statusByte,
  output logic [7:0]         deltaXLo,
  output logic [7:0]         deltaYLo,
  output logic [7:0]         deltaHi,
  output logic               motionN,
  output logic [7:0]         thrValue
);
  mdaStrobes_t stb;

  mda_ctrl #(.SHUT_W(SHUT_W), .THR_RESET(THR_RESET)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .shutter    (shutter),
    .statusRd   (statusRd),
    .statusWr   (statusWr),
    .highRd     (highRd),
    .thrWr      (thrWr),
    .thrWrData  (thrWrData),
    .stb        (stb),
    .thrValue   (thrValue)
  );

  mda_datapath #(.FRAME_W(FRAME_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .frameDx    (frameDx),
    .frameDy    (frameDy),
    .statusByte (statusByte),
    .deltaXLo   (deltaXLo),
    .deltaYLo   (deltaYLo),
    .deltaHi    (deltaHi),
    .motionN    (motionN)
  );
endmodule

// File: rtl/mda_checker.sv
module mda_checker #(
  parameter int SHUT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameValid,
  input logic [SHUT_W-1:0] shutter,
  input logic              statusRd,
  input logic              statusWr,
  input logic              highRd,
  input logic              motBit,
  input logic              ovfBit,
  input logic [7:0]        deltaXLo,
  input logic [7:0]        deltaYLo,
  input logic [7:0]        deltaHi,
  input logic              motionN,
  input logic [6:0]        thrHi
);
  logic [SHUT_W+11:0] shutW;
  logic [SHUT_W+11:0] boundW;
  logic               liftSeen;

  assign shutW    = {12'd0, shutter};
  assign boundW   = {{SHUT_W{1'b0}}, thrHi, 5'd0};
  assign liftSeen = shutW > boundW;

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    statusWr |=> (!motBit && !ovfBit && motionN && deltaXLo == 8'd0 &&
                  deltaYLo == 8'd0 && deltaHi == 8'd0)) // R5
    else $error("write did not clear");

  AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ovfBit && !statusWr && !highRd) |=>
      (ovfBit && $stable({deltaXLo, deltaYLo, deltaHi}))) // R4
    else $error("overflowed value moved");

  AST_LIFT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!motBit && !highRd && (!frameValid || liftSeen)) |=> !motBit) // R9
    else $error("lifted frame set motion");

  AST_SNAPSHOT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !statusWr && !highRd) |=>
      $stable({deltaXLo, deltaYLo, deltaHi})) // R7
    else $error("readout values moved");

  AST_PIN_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(motionN) |-> $past(frameValid || highRd)) // R3
    else $error("motion pin fell without cause");
endmodule

bind motion_delta_accum mda_checker #(.SHUT_W(SHUT_W)) u_mda_checker (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .shutter    (shutter),
  .statusRd   (statusRd),
  .statusWr   (statusWr),
  .highRd     (highRd),
  .motBit     (statusByte[7]),
  .ovfBit     (statusByte[4]),
  .deltaXLo   (deltaXLo),
  .deltaYLo   (deltaYLo),
  .deltaHi    (deltaHi),
  .motionN    (motionN),
  .thrHi      (thrValue[7:1])
);

// File: tb/test_motion_delta_accum.sv
`timescale 1ns/1ps
module test_motion_delta_accum;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic [7:0]  frameDx = '0;
  logic [7:0]  frameDy = '0;
  logic [15:0] shutter = '0;
  logic        statusRd = 1'b0;
  logic        statusWr = 1'b0;
  logic        highRd = 1'b0;
  logic        thrWr = 1'b0;
  logic [7:0]  thrWrData = '0;
  logic [7:0]  statusByte;
  logic [7:0]  deltaXLo;
  logic [7:0]  deltaYLo;
  logic [7:0]  deltaHi;
  logic        motionN;
  logic [7:0]  thrValue;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  motion_delta_accum i_motion_delta_accum (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameDx(frameDx),
    .frameDy(frameDy), .shutter(shutter), .statusRd(statusRd),
    .statusWr(statusWr), .highRd(highRd), .thrWr(thrWr),
    .thrWrData(thrWrData), .statusByte(statusByte), .deltaXLo(deltaXLo),
    .deltaYLo(deltaYLo), .deltaHi(deltaHi), .motionN(motionN),
    .thrValue(thrValue)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic putFrame(int dx, int dy, int sh);
    frameValid = 1'b1;
    frameDx = dx[7:0];
    frameDy = dy[7:0];
    shutter = sh[15:0];
  endtask

  task automatic dropFrame();
    frameValid = 1'b0;
    frameDx = '0;
    frameDy = '0;
    shutter = '0;
  endtask

  task automatic sendFrame(int dx, int dy, int sh);
    putFrame(dx, dy, sh);
    cyc();
    dropFrame();
  endtask

  task automatic pulseStatusRd();
    statusRd = 1'b1; cyc(); statusRd = 1'b0;
  endtask

  task automatic pulseHighRd();
    highRd = 1'b1; cyc(); highRd = 1'b0;
  endtask

  task automatic pulseStatusWr();
    statusWr = 1'b1; cyc(); statusWr = 1'b0;
  endtask

  task automatic setThr(int v);
    thrWr = 1'b1; thrWrData = v[7:0]; cyc(); thrWr = 1'b0;
  endtask

  task automatic expectDelta(string req, int ex, int ey);
    chk({req, " xlo"}, deltaXLo, ex & 8'hFF);
    chk({req, " ylo"}, deltaYLo, ey & 8'hFF);
    chk({req, " hi"}, deltaHi, (((ex >>> 8) & 15) << 4) | ((ey >>> 8) & 15));
  endtask

  task automatic expectStatus(string req, bit mot, bit ovf);
    chk({req, " status"}, statusByte, (mot ? 8'h80 : 8'h00) | (ovf ? 8'h10 : 8'h00));
    chk({req, " pin"}, motionN, mot ? 0 : 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 and R10: reset state
    expectStatus("R11", 1'b0, 1'b0);
    expectDelta("R11", 0, 0);
    chk("R10 reset threshold", thrValue, 8'h56);

    // R1 R2 R3 R6: every single-frame dx with a paired dy
    for (int dx = -128; dx < 128; dx++) begin
      int dy;
      dy = -dx - 1;
      sendFrame(dx, dy, 0);
      expectDelta("R1 R2 sweep", dx, dy);
      expectStatus("R3 sweep", 1'b1, 1'b0);
      pulseHighRd();
      expectDelta("R6 clear", 0, 0);
      expectStatus("R6 clear", 1'b0, 1'b0);
    end

    // R3: all-zero frame does not signal motion
    sendFrame(0, 0, 0);
    expectStatus("R3 zero frame", 1'b0, 1'b0);

    // R1 R4: positive edge of range
    for (int n = 1; n <= 16; n++) begin
      sendFrame(127, -128, 0);
      expectDelta("R1 accumulate", 127 * n, -128 * n);
    end
    sendFrame(1, 0, 0);
    expectDelta("R1 edge", 2033, -2048);
    expectStatus("R4 no ovf yet", 1'b1, 1'b0);
    sendFrame(20, 0, 0);
    expectDelta("R4 hold", 2033, -2048);
    expectStatus("R4 ovf set", 1'b1, 1'b1);
    sendFrame(-5, 3, 0);
    expectDelta("R4 frozen", 2033, -2048);
    pulseStatusRd();
    pulseHighRd();
    expectStatus("R4 ovf cleared", 1'b0, 1'b0);
    expectDelta("R4 cleared", 0, 0);

    // R4 R5: negative edge, then write with a frame in the same cycle
    for (int n = 1; n <= 16; n++) sendFrame(-128, 0, 0);
    expectDelta("R1 neg edge", -2048, 0);
    sendFrame(0, -1, 0);
    expectDelta("R1 neg y", -2048, -1);
    sendFrame(-1, 0, 0);
    expectDelta("R4 neg hold", -2048, -1);
    expectStatus("R4 neg ovf", 1'b1, 1'b1);
    statusWr = 1'b1;
    putFrame(9, 9, 0);
    cyc();
    statusWr = 1'b0;
    dropFrame();
    expectStatus("R5 write", 1'b0, 1'b0);
    expectDelta("R5 write", 0, 0);
    chk("R5 threshold untouched", thrValue, 8'h56);

    // R7: frames during readout go to the second accumulator
    sendFrame(10, -3, 0);
    pulseStatusRd();
    sendFrame(7, 7, 0);
    expectDelta("R7 frozen", 10, -3);
    sendFrame(-2, 1, 0);
    expectDelta("R7 frozen2", 10, -3);
    pulseHighRd();
    expectDelta("R7 handover", 5, 8);
    expectStatus("R7 handover", 1'b1, 1'b0);
    pulseHighRd();
    expectDelta("R6 empty", 0, 0);
    expectStatus("R6 empty", 1'b0, 1'b0);

    // R7: frame in the status-read cycle is buffered, not shown
    sendFrame(1, 1, 0);
    statusRd = 1'b1;
    putFrame(2, 2, 0);
    cyc();
    statusRd = 1'b0;
    dropFrame();
    expectDelta("R7 same cycle", 1, 1);
    pulseHighRd();
    expectDelta("R7 buffered", 2, 2);
    pulseHighRd();

    // R8: frame in the high-read cycle is kept
    sendFrame(3, 3, 0);
    pulseStatusRd();
    sendFrame(4, -6, 0);
    highRd = 1'b1;
    putFrame(-9, 2, 0);
    cyc();
    highRd = 1'b0;
    dropFrame();
    expectDelta("R8 kept", -5, -4);
    expectStatus("R8 kept", 1'b1, 1'b0);
    pulseStatusWr();

    // R9 R10: lift bound for every threshold value
    for (int t = 0; t < 256; t++) begin
      int lim;
      setThr(t);
      chk("R10 threshold write", thrValue, t);
      lim = (t >> 1) * 32;
      sendFrame(1, 0, lim);
      expectDelta("R9 at bound", 1, 0);
      sendFrame(1, 0, lim + 1);
      expectDelta("R9 above bound", 1, 0);
      pulseStatusWr();
    end
    setThr(8'h56);
    sendFrame(5, 5, 16'hFFFF);
    expectStatus("R9 lifted no motion", 1'b0, 1'b0);
    expectDelta("R9 lifted", 0, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule